// File: doc/BRIEF.md
# Flat-Panel Pixel Lane Serializer

This block turns one parallel pixel (three 8-bit colour channels plus horizontal sync, vertical sync and data enable) into seven-slot serial words on four data lanes and a clock lane. It runs on a bit clock at seven times the pixel rate. Every seventh cycle it raises a request strobe and captures the next pixel. That pixel is then sent, one slot per cycle, starting in the very next cycle. There is no idle cycle between pixels.

A two-bit layout select chooses how colour and control bits are placed in the slots. An 18-bit layout uses three lanes and the upper six bits of each colour. A first 24-bit layout adds the two low colour bits on lane 3. A second 24-bit layout keeps the low six bits on lanes 0 to 2 and sends the top two bits on lane 3. A mirror input sends every data lane's slots in reverse order. Layout and mirror are captured together with the pixel, so one pixel never mixes two settings.

Top module: `lvds_lane_serializer`

## Requirements
- R1: An internal slot counter steps 0,1,...,6,0 on every clock. `pix_req_o` is high exactly in the cycle where the slot is 6, so it pulses once every 7 cycles.
- R2: `clk_lane_o` follows the slot: high in slots 0, 1, 5 and 6, and low in slots 2, 3 and 4.
- R3: With `map_sel_i` = 0 (18-bit), and also with the unused value 3, lane 3 is 0 in every slot and colour bits [1:0] have no effect. Written as slot 0..6, lane 0 = g2,r7,r6,r5,r4,r3,r2; lane 1 = b3,b2,g7,g6,g5,g4,g3; lane 2 = de,vs,hs,b7,b6,b5,b4.
- R4: With `map_sel_i` = 1, lanes 0 to 2 match the R3 layout. Lane 3 in slots 0..6 = 0,b1,b0,g1,g0,r1,r0.
- R5: With `map_sel_i` = 2, slots 0..6 are: lane 0 = g0,r5,r4,r3,r2,r1,r0; lane 1 = b1,b0,g5,g4,g3,g2,g1; lane 2 = de,vs,hs,b5,b4,b3,b2; lane 3 = 0,b7,b6,g7,g6,r7,r6.
- R6: Slot 0 of lane 2 carries data enable, slot 1 carries vertical sync and slot 2 carries horizontal sync. Slot 0 of lane 3 is always 0.
- R7: With the mirror setting at 1, each data lane sends in slot k the bit that slot 6-k would carry without mirroring. The clock lane is not affected.
- R8: The pixel inputs are captured in the cycle where `pix_req_o` is high. The captured pixel appears from the next cycle (slot 0) and is held for 7 slots. Input changes during those slots have no effect on the output.
- R9: `map_sel_i` and `mirror_i` are captured only in the cycle where `pix_req_o` is high. Changes at other times have no effect on the pixel being sent.
- R10: While `rst_ni` is low and for the first pixel period after release, all data lanes output 0, the slot is 0 (clock lane high) and `pix_req_o` is 0 until slot 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| red_i | input | 8 | Red channel of the next pixel |
| green_i | input | 8 | Green channel of the next pixel |
| blue_i | input | 8 | Blue channel of the next pixel |
| hsync_i | input | 1 | Horizontal sync of the next pixel |
| vsync_i | input | 1 | Vertical sync of the next pixel |
| de_i | input | 1 | Data enable of the next pixel |
| map_sel_i | input | 2 | Layout select: 0 = 18-bit, 1 = 24-bit A, 2 = 24-bit B, 3 = 18-bit |
| mirror_i | input | 1 | Reverse the slot order on all data lanes |
| pix_req_o | output | 1 | High in the cycle where the pixel inputs are captured |
| lane_o | output | 4 | Data lane bits for the current slot |
| clk_lane_o | output | 1 | Clock lane bit for the current slot |

## Verification
The hardest case to reach from the ports is a change of layout, mirror or pixel inputs while a pixel is still being sent. If such a change leaked through, the output would mix old and new settings for only part of the seven slots. To reach this case, the driver applies a pixel on the request strobe. Three cycles later it inverts every input, including layout and mirror, and it restores the inputs only on the next strobe. The scoreboard still expects all seven slots from the settings captured on the strobe. Back-to-back pixels that switch between all four select values, with mirroring on and off, check that no gap or stale slot appears at the pixel boundary.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOTS   = 7;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;
  localparam int FIELD_W = 6;

  typedef logic [SLOTS-1:0]   word_t;
  typedef logic [SLOT_W-1:0]  slot_t;

  // bit k = clock lane level in slot k
  localparam word_t CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18  = 2'd0,
    MAP_24A = 2'd1,
    MAP_24B = 2'd2,
    MAP_RSV = 2'd3
  } map_e;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;
endpackage

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr
  import lvds_ser_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_t slot_o,
  output logic  last_o,
  output logic  clk_lane_o
);
  localparam slot_t LAST = slot_t'(SLOTS - 1);

  slot_t slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + slot_t'(1);
  end

  assign slot_o     = slot_q;
  assign last_o     = (slot_q == LAST);
  assign clk_lane_o = CLK_PATTERN[slot_q];

  a_r1_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);
  a_r1_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
  a_r2_clk_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_lane_o) |-> slot_q == slot_t'(5));
  a_r2_clk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_lane_o) |-> slot_q == slot_t'(2));
endmodule

// File: rtl/lvds_pixel_hold.sv
module lvds_pixel_hold
  import lvds_ser_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  pixel_t pix_i,
  input  map_e   map_i,
  input  logic   mirror_i,
  output pixel_t pix_o,
  output map_e   map_o,
  output logic   mirror_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o    <= '0;
      map_o    <= MAP_18;
      mirror_o <= 1'b0;
    end else if (load_i) begin
      pix_o    <= pix_i;
      map_o    <= map_i;
      mirror_o <= mirror_i;
    end
  end

  a_r9_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(map_o) && $stable(mirror_o)));
  a_r8_pix_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(pix_o));
endmodule

// File: rtl/lvds_lane_packer.sv
module lvds_lane_packer
  import lvds_ser_pkg::*;
(
  input  pixel_t pix_i,
  input  map_e   map_i,
  output word_t  words_o [LANES]
);
  logic               low_field;
  logic [FIELD_W-1:0] rf, gf, bf;
  logic [1:0]         rx, gx, bx;

  always_comb begin
    low_field = (map_i == MAP_24B);
    rf = low_field ? pix_i.r[FIELD_W-1:0] : pix_i.r[COLOR_W-1:COLOR_W-FIELD_W];
    gf = low_field ? pix_i.g[FIELD_W-1:0] : pix_i.g[COLOR_W-1:COLOR_W-FIELD_W];
    bf = low_field ? pix_i.b[FIELD_W-1:0] : pix_i.b[COLOR_W-1:COLOR_W-FIELD_W];
    // bits left over from the 6-bit field go to lane 3
    rx = low_field ? pix_i.r[COLOR_W-1:FIELD_W] : pix_i.r[1:0];
    gx = low_field ? pix_i.g[COLOR_W-1:FIELD_W] : pix_i.g[1:0];
    bx = low_field ? pix_i.b[COLOR_W-1:FIELD_W] : pix_i.b[1:0];

    words_o[0][0] = gf[0];
    for (int s = 1; s < SLOTS; s++) words_o[0][s] = rf[SLOTS-1-s];

    words_o[1][0] = bf[1];
    words_o[1][1] = bf[0];
    for (int s = 2; s < SLOTS; s++) words_o[1][s] = gf[SLOTS-s];

    words_o[2][0] = pix_i.de;
    words_o[2][1] = pix_i.vs;
    words_o[2][2] = pix_i.hs;
    for (int s = 3; s < SLOTS; s++) words_o[2][s] = bf[SLOTS+1-s];

    if (map_i == MAP_24A || map_i == MAP_24B)
      words_o[3] = {rx[0], rx[1], gx[0], gx[1], bx[0], bx[1], 1'b0};
    else
      words_o[3] = '0;
  end
endmodule

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer
  import lvds_ser_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic [1:0]         map_sel_i,
  input  logic               mirror_i,
  output logic               pix_req_o,
  output logic [LANES-1:0]   lane_o,
  output logic               clk_lane_o
);
  slot_t  slot;
  slot_t  slot_rev;
  logic   last;
  pixel_t pix_in, pix_q;
  map_e   map_q;
  logic   mirror_q;
  word_t  words [LANES];

  assign pix_in = '{r: red_i, g: green_i, b: blue_i, hs: hsync_i, vs: vsync_i, de: de_i};

  lvds_slot_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_o     (slot),
    .last_o     (last),
    .clk_lane_o (clk_lane_o)
  );

  lvds_pixel_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (last),
    .pix_i    (pix_in),
    .map_i    (map_e'(map_sel_i)),
    .mirror_i (mirror_i),
    .pix_o    (pix_q),
    .map_o    (map_q),
    .mirror_o (mirror_q)
  );

  lvds_lane_packer u_pack (
    .pix_i   (pix_q),
    .map_i   (map_q),
    .words_o (words)
  );

  assign slot_rev  = slot_t'(SLOTS - 1) - slot;
  assign pix_req_o = last;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_o[l] = mirror_q ? words[l][slot_rev] : words[l][slot];
  end

  a_r3_lane3_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_q == MAP_18 || map_q == MAP_RSV) |-> !lane_o[3]);
  a_r6_ctl3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == '0 && !mirror_q) |-> !lane_o[3]);
  a_r10_req_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> clk_lane_o);
endmodule

// File: tb/lvds_lane_serializer_tb.sv
`timescale 1ns/1ps
module lvds_lane_serializer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] red_i = '0, green_i = '0, blue_i = '0;
  logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [1:0] map_sel_i = '0;
  logic       mirror_i = 1'b0;
  logic       pix_req_o;
  logic [3:0] lane_o;
  logic       clk_lane_o;

  always #4 clk_i = ~clk_i;

  lvds_lane_serializer u_dut (.*);

  typedef struct { logic [27:0] w; logic mir; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // returns {lane3,lane2,lane1,lane0}; bit k of each 7-bit word is slot k
  function automatic logic [27:0] exp_pix(input logic [7:0] r, g, b, input logic hs, vs, de,
                                          input logic [1:0] m);
    logic [6:0] l0, l1, l2, l3;
    if (m == 2'd2) begin
      l0 = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
      l1 = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
      l2 = {b[2], b[3], b[4], b[5], hs, vs, de};
      l3 = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
    end else begin
      l0 = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
      l1 = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
      l2 = {b[4], b[5], b[6], b[7], hs, vs, de};
      l3 = (m == 2'd1) ? {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0} : 7'd0;
    end
    return {l3, l2, l1, l0};
  endfunction

  task automatic send_pixel(input logic [7:0] r, g, b, input logic hs, vs, de,
                            input logic [1:0] m, input logic mir, input string tag,
                            input bit glitch);
    item_t it;
    do @(negedge clk_i); while (!pix_req_o);
    red_i = r; green_i = g; blue_i = b;
    hsync_i = hs; vsync_i = vs; de_i = de;
    map_sel_i = m; mirror_i = mir;
    it.w = exp_pix(r, g, b, hs, vs, de, m); it.mir = mir; it.tag = tag;
    q.push_back(it);
    if (glitch) begin
      repeat (3) @(negedge clk_i);
      red_i = ~r; green_i = ~g; blue_i = ~b;
      hsync_i = ~hs; vsync_i = ~vs; de_i = ~de;
      map_sel_i = ~m; mirror_i = ~mir;
    end
  endtask

  // monitor / scoreboard
  item_t cur;
  int    pos = 0;
  bit    active = 0, pend = 0, run_mon = 0;
  always @(negedge clk_i) begin
    if (run_mon) begin
      if (pend) begin
        pend = 0;
        if (q.size() > 0) begin cur = q.pop_front(); pos = 0; active = 1; end
        else active = 0;
      end
      if (active) begin
        logic [3:0] expl;
        for (int l = 0; l < 4; l++)
          expl[l] = cur.mir ? cur.w[l*7 + 6 - pos] : cur.w[l*7 + pos];
        chk(lane_o === expl, cur.tag, {28'd0, lane_o}, {28'd0, expl});
        chk(clk_lane_o === (pos inside {0, 1, 5, 6}), "R2 clock lane", {31'd0, clk_lane_o},
            {31'd0, pos inside {0, 1, 5, 6}});
        chk(pix_req_o === (pos == 6), "R1 request", {31'd0, pix_req_o}, {31'd0, pos == 6});
        pos++;
        if (pos == 7) active = 0;
      end
      if (pix_req_o) pend = 1;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: state while in reset
    chk(lane_o === 4'd0, "R10 reset lanes", {28'd0, lane_o}, 0);
    chk(clk_lane_o === 1'b1, "R10 reset clock lane", {31'd0, clk_lane_o}, 1);
    chk(pix_req_o === 1'b0, "R10 reset request", {31'd0, pix_req_o}, 0);
    red_i = 8'hff; green_i = 8'hff; blue_i = 8'hff; de_i = 1'b1;
    rst_ni = 1'b1;
    run_mon = 1;
    for (int k = 1; k < 6; k++) begin
      @(negedge clk_i);
      chk(lane_o === 4'd0, "R10 first period lanes", {28'd0, lane_o}, 0);
      chk(clk_lane_o === (k inside {1, 5}), "R2 first period clock", {31'd0, clk_lane_o},
          {31'd0, k inside {1, 5}});
      chk(pix_req_o === 1'b0, "R1 no early request", {31'd0, pix_req_o}, 0);
    end
    // layouts, controls, mirror
    send_pixel(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R3 18-bit", 0);
    send_pixel(8'h03, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R3 low bits ignored", 0);
    send_pixel(8'h5A, 8'h96, 8'h69, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, "R3 select 3", 0);
    send_pixel(8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, "R4 24-bit A", 0);
    send_pixel(8'h03, 8'h02, 8'h01, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R4 lane 3 bits", 0);
    send_pixel(8'hC1, 8'h82, 8'h44, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, "R5 24-bit B", 0);
    send_pixel(8'h3F, 8'hC0, 8'h15, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, "R5 field split", 0);
    send_pixel(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, "R6 hsync slot", 0);
    send_pixel(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, "R6 vsync slot", 0);
    send_pixel(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R6 de slot", 0);
    send_pixel(8'hA5, 8'h3C, 8'hC3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, "R7 mirror 18-bit", 0);
    send_pixel(8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, "R7 mirror 24-bit A", 0);
    send_pixel(8'hC1, 8'h82, 8'h44, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, "R7 mirror 24-bit B", 0);
    send_pixel(8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, "R8 R9 mid-pixel change", 1);
    send_pixel(8'hE7, 8'h18, 8'h99, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, "R8 R9 mid-pixel change mirrored", 1);
    send_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, "R8 R9 back-to-back", 0);
    send_pixel(8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R8 back-to-back", 0);
    repeat (20) @(negedge clk_i);
    chk(q.size() == 0, "R8 all pixels sent", q.size(), 0);
    finish_run();
  end
endmodule